// File: doc/BRIEF.md
# Serial Memory Status Register Front End

This block is the command front end of a serial memory device. It is an SPI slave in mode 0. It decodes the instructions that concern the status byte and owns the state behind that byte. A host selects the device with an active-low chip select and shifts in an 8-bit instruction, most significant bit first. Depending on the instruction, the host can then read the status byte back, arm or disarm the write-enable latch, or load new protection settings. The array logic elsewhere on the chip reads the protect fields and the latch state from this block's outputs. That logic also reports its own programming activity on a busy input.

The SPI pins are sampled by the system clock through a synchronizer of configurable depth. The block detects SCK edges and the chip-select release in that clock domain. An accepted status write starts an internal timer that stands in for the nonvolatile programming time. While the timer runs, or while the external busy input is high, the in-progress flag reads 1. The status byte can still be read at any time. When the timer expires, the block clears both the in-progress flag and the write-enable latch.

Top module: `spi_status_ctrl`

## Requirements
- R1: Instruction 0x05 read-status: after its 8 instruction bits, the status byte is returned on the serial output over the next 8 SCK cycles, bit 7 first. The output changes after each SCK falling edge and is valid at the following rising edge.
- R2: The output enable `so_oe` is 0 while instruction bits are being shifted in and whenever `cs_n` is high (deselected).
- R3: Status byte layout: bit 7 = protect-enable, bits 6..4 = 0, bit 3 = BP1, bit 2 = BP0, bit 1 = write-enable latch, bit 0 = write-in-progress.
- R4: Write-in-progress reads 1 exactly while `ext_busy` is high or the internal write timer runs. No instruction data can set it.
- R5: Instruction 0x06 sets the write-enable latch and 0x04 clears it, on the chip-select release, whatever the protection settings are.
- R6: Instruction 0x01 followed by a data byte loads protect-enable from data bit 7 and BP1..BP0 from data bits 3..2, but only when the latch is 1 and write-in-progress is 0. Otherwise nothing changes.
- R7: An accepted 0x01 write holds write-in-progress at 1 for `WR_CYCLES` system clocks. At the end of that time, write-in-progress and the write-enable latch both return to 0.
- R8: The status byte can be read while a write cycle runs, and it then shows write-in-progress = 1.
- R9: An instruction takes effect only if chip select rises after a whole number of bytes. Partial bytes and unknown opcodes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| ext_busy | input | 1 | Write-busy from the array write timer |
| so_data | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial output enable (0 = high impedance) |
| wel | output | 1 | Write-enable latch |
| bp | output | 2 | Block-protect field BP1..BP0 |
| wpen | output | 1 | Protect-enable bit |
| wip | output | 1 | Write-in-progress flag |

## Verification
Faults in the latch or protect registers reach the `wel`, `bp` and `wpen` pins a few system clocks after chip select rises. The same faults appear in the next read-status byte. A wrong bit or byte count shows up within one transaction in two ways: the output turns on during the instruction, or the status byte comes back shifted. A timer that runs short, runs long, or fails to clear the latch is caught by a status read taken during the write and by a port check made one write period after the status write.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
   localparam logic [7:0] OPC_WRSR = 8'h01;
   localparam logic [7:0] OPC_WRDI = 8'h04;
   localparam logic [7:0] OPC_RDSR = 8'h05;
   localparam logic [7:0] OPC_WREN = 8'h06;

   // positions of writable fields inside the data byte of a status write
   localparam int unsigned POS_WPEN = 7;
   localparam int unsigned POS_BP1  = 3;
   localparam int unsigned POS_BP0  = 2;

   typedef struct packed {
      logic       wpen;
      logic [1:0] bp;
   } prot_t;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
   parameter int unsigned    W      = 3,
   parameter int unsigned    STAGES = 2,
   parameter logic [W-1:0]   RST    = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ssr_frame.sv
module ssr_frame
   import spi_stat_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sck_q,
   input  logic        cs_q,
   input  logic        si_q,
   input  logic [7:0]  status_in,
   output logic        so_data,
   output logic        so_oe,
   output logic        cmd_valid,
   output logic [7:0]  cmd_op,
   output logic        cmd_has_data,
   output prot_t       cmd_fields
);
   logic       sck_d, cs_d;
   logic [2:0] bit_cnt;
   logic [1:0] byte_cnt;
   logic [7:0] shreg, tx;
   logic       tx_arm;
   logic [7:0] sh_nx, cur_op;
   logic       sck_rise, sck_fall;

   assign sck_rise = sck_q & ~sck_d & ~cs_q;
   assign sck_fall = ~sck_q & sck_d & ~cs_q;
   assign sh_nx    = {shreg[6:0], si_q};
   assign cur_op   = (byte_cnt == 2'd0) ? sh_nx : cmd_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d        <= 1'b0;
         cs_d         <= 1'b1;
         bit_cnt      <= '0;
         byte_cnt     <= '0;
         shreg        <= '0;
         tx           <= '0;
         tx_arm       <= 1'b0;
         so_data      <= 1'b0;
         so_oe        <= 1'b0;
         cmd_valid    <= 1'b0;
         cmd_op       <= '0;
         cmd_has_data <= 1'b0;
         cmd_fields   <= '0;
      end else begin
         sck_d     <= sck_q;
         cs_d      <= cs_q;
         cmd_valid <= 1'b0;
         if (cs_q) begin
            if (!cs_d) begin
               cmd_valid    <= (bit_cnt == 3'd0) && (byte_cnt != 2'd0);
               cmd_has_data <= (byte_cnt >= 2'd2);
            end
            bit_cnt  <= '0;
            byte_cnt <= '0;
            tx_arm   <= 1'b0;
            so_oe    <= 1'b0;
         end else if (sck_rise) begin
            shreg   <= sh_nx;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
               if (byte_cnt == 2'd0) cmd_op <= sh_nx;
               if (byte_cnt == 2'd1)
                  cmd_fields <= '{wpen: sh_nx[POS_WPEN],
                                  bp:   {sh_nx[POS_BP1], sh_nx[POS_BP0]}};
               if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
               if (cur_op == OPC_RDSR) begin
                  tx     <= status_in;
                  tx_arm <= 1'b1;
               end
            end
         end else if (sck_fall && tx_arm) begin
            so_oe   <= 1'b1;
            so_data <= tx[7];
            tx      <= {tx[6:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/ssr_status.sv
module ssr_status
   import spi_stat_pkg::*;
#(
   parameter int unsigned WR_CYCLES = 2000,
   parameter prot_t       PROT_INIT = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_op,
   input  logic       cmd_has_data,
   input  prot_t      cmd_fields,
   input  logic       ext_busy,
   output logic       wel,
   output prot_t      prot,
   output logic       tmr_busy,
   output logic       wip,
   output logic [7:0] status
);
   localparam int unsigned TW = $clog2(WR_CYCLES + 1);

   logic [TW-1:0] cnt;

   assign tmr_busy = (cnt != '0);
   assign wip      = ext_busy | tmr_busy;
   assign status   = {prot.wpen, 3'b000, prot.bp, wel, wip};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         prot <= PROT_INIT;
         cnt  <= '0;
      end else begin
         if (cmd_valid) begin
            case (cmd_op)
               OPC_WREN: wel <= 1'b1;
               OPC_WRDI: wel <= 1'b0;
               OPC_WRSR: if (cmd_has_data && wel && !wip) begin
                  prot <= cmd_fields;
                  cnt  <= TW'(WR_CYCLES);
               end
               default: ;
            endcase
         end
         if (tmr_busy) begin
            cnt <= cnt - TW'(1);
            if (cnt == TW'(1)) wel <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
   import spi_stat_pkg::*;
#(
   parameter int unsigned WR_CYCLES   = 2000,
   parameter int unsigned SYNC_STAGES = 2,
   parameter prot_t       PROT_INIT   = '0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck,
   input  logic       cs_n,
   input  logic       si,
   input  logic       ext_busy,
   output logic       so_data,
   output logic       so_oe,
   output logic       wel,
   output logic [1:0] bp,
   output logic       wpen,
   output logic       wip
);
   if (WR_CYCLES < 1) begin : g_bad_cycles
      $error("WR_CYCLES must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic       sck_q, cs_q, si_q;
   logic       cmd_valid, cmd_has_data, tmr_busy;
   logic [7:0] cmd_op, status;
   prot_t      cmd_fields, prot;

   ssr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sck, cs_n, si}), .q({sck_q, cs_q, si_q})
   );

   ssr_frame i_frame (
      .clk(clk), .rst_n(rst_n),
      .sck_q(sck_q), .cs_q(cs_q), .si_q(si_q),
      .status_in(status),
      .so_data(so_data), .so_oe(so_oe),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_has_data(cmd_has_data), .cmd_fields(cmd_fields)
   );

   ssr_status #(.WR_CYCLES(WR_CYCLES), .PROT_INIT(PROT_INIT)) i_status (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_has_data(cmd_has_data), .cmd_fields(cmd_fields),
      .ext_busy(ext_busy),
      .wel(wel), .prot(prot), .tmr_busy(tmr_busy),
      .wip(wip), .status(status)
   );

   assign bp   = prot.bp;
   assign wpen = prot.wpen;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_q,
   input logic       so_oe,
   input logic       wel,
   input logic [1:0] bp,
   input logic       wpen,
   input logic       tmr_busy
);
   AST_SO_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> !so_oe); // R2
   AST_PROT_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({wpen, bp}) |-> $past(wel)); // R6
   AST_TIMER_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tmr_busy) |-> $past(wel)); // R6
   AST_TIMER_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tmr_busy) |-> !wel); // R7
endmodule

bind spi_status_ctrl ssr_checker i_chk (
   .clk(clk), .rst_n(rst_n), .cs_q(cs_q), .so_oe(so_oe),
   .wel(wel), .bp(bp), .wpen(wpen), .tmr_busy(tmr_busy)
);

// File: tb/test_spi_status_ctrl.sv
module test_spi_status_ctrl;
   localparam int unsigned WRC  = 400;
   localparam int          HALF = 6;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0, ext_busy = 1'b0;
   logic so_data, so_oe, wel, wpen, wip;
   logic [1:0] bp;

   int n_cmp = 0, n_err = 0;
   logic       m_wel = 1'b0, m_wpen = 1'b0;
   logic [1:0] m_bp = 2'b00;
   logic [7:0] g_rx;
   logic       g_oe_cmd, g_oe_data;

   always #4 clk = ~clk;

   spi_status_ctrl #(.WR_CYCLES(WRC)) i_spi_status_ctrl (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
      .ext_busy(ext_busy), .so_data(so_data), .so_oe(so_oe),
      .wel(wel), .bp(bp), .wpen(wpen), .wip(wip)
   );

   function automatic logic [7:0] exp_status(input logic busy);
      return {m_wpen, 3'b000, m_bp, m_wel, busy};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic spi_xfer(input logic [15:0] word, input int nbits);
      g_rx = '0; g_oe_cmd = 1'b0; g_oe_data = 1'b1;
      cs_n = 1'b0;
      tick(HALF);
      for (int i = 0; i < nbits; i++) begin
         si = word[15-i];
         tick(HALF);
         if (i < 8) g_oe_cmd = g_oe_cmd | so_oe;
         else begin
            g_oe_data = g_oe_data & so_oe;
            g_rx[15-i] = so_data;
         end
         sck = 1'b1;
         tick(HALF);
         sck = 1'b0;
      end
      tick(HALF);
      cs_n = 1'b1;
      tick(12);
   endtask

   task automatic check_ports(input string req);
      chk({req, " wel"}, {31'd0, wel}, {31'd0, m_wel});
      chk({req, " bp"}, {30'd0, bp}, {30'd0, m_bp});
      chk({req, " wpen"}, {31'd0, wpen}, {31'd0, m_wpen});
   endtask

   task automatic do_read(input logic busy, input string req);
      spi_xfer({spi_stat_pkg::OPC_RDSR, 8'h00}, 16);
      chk("R2 oe during instruction", {31'd0, g_oe_cmd}, 32'd0);
      chk("R1 oe during data", {31'd0, g_oe_data}, 32'd1);
      chk({req, " status byte"}, {24'd0, g_rx}, {24'd0, exp_status(busy)});
      chk("R2 oe after deselect", {31'd0, so_oe}, 32'd0);
   endtask

   // status write; models acceptance, then checks the timed cycle
   task automatic do_wrsr(input logic [7:0] d, input int nbits);
      logic acc;
      acc = (nbits == 16) && m_wel && !ext_busy;
      spi_xfer({spi_stat_pkg::OPC_WRSR, d}, nbits);
      if (acc) begin
         m_wpen = d[7];
         m_bp   = d[3:2];
         chk("R7 wip set after write", {31'd0, wip}, 32'd1);
         check_ports("R6 fields loaded");
         do_read(1'b1, "R8 read during write");
         tick(WRC);
         m_wel = 1'b0;
         chk("R7 wip cleared", {31'd0, wip}, 32'd0);
         check_ports("R7 latch cleared");
      end else begin
         chk("R4 wip unchanged", {31'd0, wip}, {31'd0, ext_busy});
         check_ports("R6 write ignored");
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end

   initial begin
      logic [7:0] junk;
      void'($urandom(32'h5EED));
      tick(5);
      rst_n = 1'b1;
      tick(5);
      // reset state
      chk("R2 reset oe", {31'd0, so_oe}, 32'd0);
      chk("R4 reset wip", {31'd0, wip}, 32'd0);
      check_ports("R3 reset");
      do_read(1'b0, "R3 reset");
      // write without latch: ignored
      do_wrsr(8'hFF, 16);
      // latch set
      spi_xfer({spi_stat_pkg::OPC_WREN, 8'h00}, 8);
      m_wel = 1'b1;
      check_ports("R5 write enable");
      do_read(1'b0, "R5 latch visible");
      // external busy visible and blocks status write
      ext_busy = 1'b1;
      tick(4);
      do_read(1'b1, "R4 external busy");
      do_wrsr(8'h8C, 16);
      ext_busy = 1'b0;
      tick(4);
      // accepted write with all-ones data: unused bits and bit0 stay clear
      do_wrsr(8'hFF, 16);
      do_read(1'b0, "R3 layout after write");
      // latch control works while protection is set
      spi_xfer({spi_stat_pkg::OPC_WREN, 8'h00}, 8);
      m_wel = 1'b1;
      check_ports("R5 enable under protection");
      spi_xfer({spi_stat_pkg::OPC_WRDI, 8'h00}, 8);
      m_wel = 1'b0;
      check_ports("R5 disable under protection");
      // unknown opcode and partial byte
      spi_xfer({8'h07, 8'h00}, 8);
      check_ports("R9 unknown opcode");
      spi_xfer({spi_stat_pkg::OPC_WREN, 8'h00}, 7);
      check_ports("R9 partial byte");
      spi_xfer({spi_stat_pkg::OPC_WREN, 8'h00}, 9);
      check_ports("R9 extra bit");
      // random mix
      for (int k = 0; k < 60; k++) begin
         ext_busy = ($urandom % 4) == 0;
         tick(4);
         case ($urandom % 6)
            0: begin
               spi_xfer({spi_stat_pkg::OPC_WREN, 8'h00}, 8);
               m_wel = 1'b1;
               check_ports("R5 random enable");
            end
            1: begin
               spi_xfer({spi_stat_pkg::OPC_WRDI, 8'h00}, 8);
               m_wel = 1'b0;
               check_ports("R5 random disable");
            end
            2: do_wrsr(8'($urandom), 16);
            3: do_read(ext_busy, "R1 random read");
            4: begin
               junk = 8'($urandom);
               if (junk == 8'h01 || junk == 8'h04 || junk == 8'h05 || junk == 8'h06)
                  junk = junk ^ 8'h80;
               spi_xfer({junk, 8'($urandom)}, 16);
               check_ports("R9 random junk opcode");
            end
            default: begin
               if ($urandom % 2 == 0) begin
                  spi_xfer({(m_wel ? spi_stat_pkg::OPC_WRDI : spi_stat_pkg::OPC_WREN), 8'h00},
                           1 + int'($urandom % 7));
                  check_ports("R9 random partial latch");
               end else do_wrsr(8'($urandom), 9 + int'($urandom % 7));
            end
         endcase
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
   end
endmodule